// File: doc/BRIEF.md
# PCI Type 0 Configuration Target

This block is the configuration-space slave of a single-function PCI device. The bus handshake is reduced to an address strobe and a data strobe sharing one 32-bit AD bus. The block claims a configuration cycle when its select line is high during the address phase and the two low address bits are zero. It then serves one DWORD of a 16-DWORD header. The header holds read-only identity fields, a partly writable command word, a fixed status word, a latency timer, an I/O base address and an interrupt line.

Writes are qualified per byte lane by active-high byte enables. Reads always return the whole little-endian DWORD, and the data arrives one cycle after the data strobe. The block has two active-low resets. The power-on reset initialises every writable field. The hard reset clears only the command word. The soft-reset and sleep inputs have no effect on the header. The header can be accessed from the first cycle after power-on reset is released, so no external loader has to finish first.

Top module: `cfg_target`

## Requirements
- R1: `devsel_o` rises one cycle after an address strobe that has `idsel_i` high and `ad_i[1:0]`=00. It falls one cycle after the following data strobe. An address strobe with `idsel_i` low is not claimed.
- R2: An address strobe with `ad_i[1:0]` other than 00 is not claimed. Its data strobe changes no register and produces no `rvalid_o`.
- R3: `ad_i[7:2]` in the address phase give the DWORD index. The function bits `ad_i[10:8]` and the bits `ad_i[31:11]` have no influence on the access.
- R4: On a write, `byte_en_i[k]` stores `ad_i[8k+7:8k]` into byte k of the selected DWORD. Unselected bytes keep their value, and a write with `byte_en_i`=0000 changes nothing. A read returns the full DWORD on `rdata_o`, whatever the byte enables are, with `rvalid_o` high for exactly the one cycle after the data strobe.
- R5: The following fields are read-only and ignore writes. DWORD 0 is {DEVICE_ID, VENDOR_ID}. DWORD 2 is {CLASS_CODE, REVISION}. DWORD 3 bits 23:16 read 00h, so bit 23 = 0 and the device reports a single function. DWORD 15 bits 15:8 read INT_PIN.
- R6: The following locations read zero and ignore writes: DWORDs 5 to 14, DWORD 3 bytes 0 and 3, DWORD 15 bytes 2 and 3, and DWORD indices 16 to 63 (`ad_i[7:6]`≠00).
- R7: DWORD 1 bits 15:0 form the command word, and only the bits set in CMD_WMASK (default 0147h) can be written; the other bits read 0. DWORD 1 bits 31:16 read the fixed STATUS_VAL.
- R8: DWORD 4 bits 31:5 form a writable base address. Bits 4:0 always read 00001b, which marks an I/O window of 32 bytes.
- R9: The latency timer (DWORD 3 bits 15:8) and the interrupt line (DWORD 15 bits 7:0) are fully writable.
- R10: `rst_ni` low clears only the command word; the latency timer, interrupt line and base address keep their values. `por_ni` low clears every writable field, which leaves the base address reading 00000001h.
- R11: Activity on `soft_rst_i` and `sleep_i` changes no header register.
- R12: A configuration read issued in the first cycle after `por_ni` is released is claimed and returns correct data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Hard reset, active low, asynchronous; clears the command word |
| por_ni | input | 1 | Power-on reset, active low, asynchronous; clears all writable fields |
| soft_rst_i | input | 1 | Soft reset request; has no effect on the header |
| sleep_i | input | 1 | Sleep request; has no effect on the header |
| idsel_i | input | 1 | Configuration select, sampled during the address phase |
| addr_strobe_i | input | 1 | Address phase valid |
| data_strobe_i | input | 1 | Data phase valid |
| cfg_write_i | input | 1 | Direction of the cycle, sampled during the address phase (1 = write) |
| ad_i | input | 32 | Address during the address phase, write data during the data phase |
| byte_en_i | input | 4 | Active-high byte lane enables for the data phase |
| devsel_o | output | 1 | Cycle claimed |
| rdata_o | output | 32 | Read data |
| rvalid_o | output | 1 | Read data valid, one cycle |

## Verification
A corrupted index or direction latch shows up as wrong or missing `rdata_o` one cycle after the data strobe, or as a register change observed at the next read. A mis-decoded claim shows up at `devsel_o` one cycle after the address strobe. Wrong byte-lane steering, or a write mask applied where it does not belong, is visible on the first read-back of the affected DWORD. Wrong reset scoping appears on the first read after the reset pulse ends.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
  localparam int IDX_W = 6;
  localparam logic [IDX_W-1:0] IDX_ID    = 6'd0;
  localparam logic [IDX_W-1:0] IDX_CMD   = 6'd1;
  localparam logic [IDX_W-1:0] IDX_CLASS = 6'd2;
  localparam logic [IDX_W-1:0] IDX_MISC  = 6'd3;
  localparam logic [IDX_W-1:0] IDX_BAR   = 6'd4;
  localparam logic [IDX_W-1:0] IDX_INT   = 6'd15;
  localparam int BAR_LSB = 5;  // 32-byte aligned I/O window

  typedef struct packed {
    logic              wr;
    logic [IDX_W-1:0]  idx;
  } cfg_req_t;

  function automatic logic idx_reserved(input logic [IDX_W-1:0] idx);
    return (idx > IDX_BAR && idx < IDX_INT) || (idx > IDX_INT);
  endfunction
endpackage

// File: rtl/cfg_addr_decode.sv
module cfg_addr_decode
  import cfg_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             por_ni,
  input  logic             idsel_i,
  input  logic             addr_strobe_i,
  input  logic             data_strobe_i,
  input  logic             cfg_write_i,
  input  logic [7:0]       ad_lo_i,
  output logic             devsel_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             wr_en_o,
  output logic             rd_en_o
);
  cfg_req_t req_q;
  logic     devsel_q;
  logic     claim;

  assign claim = addr_strobe_i & idsel_i & (ad_lo_i[1:0] == 2'b00);

  always_ff @(posedge clk_i or negedge rst_ni or negedge por_ni) begin
    if (!rst_ni || !por_ni) begin
      devsel_q <= 1'b0;
      req_q    <= '0;
    end else if (claim) begin
      devsel_q   <= 1'b1;
      req_q.idx  <= ad_lo_i[7:2];
      req_q.wr   <= cfg_write_i;
    end else if (devsel_q && data_strobe_i) begin
      devsel_q <= 1'b0;
    end
  end

  assign devsel_o = devsel_q;
  assign idx_o    = req_q.idx;
  assign wr_en_o  = devsel_q & data_strobe_i & req_q.wr;
  assign rd_en_o  = devsel_q & data_strobe_i & ~req_q.wr;

  p_claim_src_r1: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    $rose(devsel_o) |-> $past(addr_strobe_i && idsel_i));
  p_devsel_drop_r1: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    (devsel_o && data_strobe_i && !addr_strobe_i) |=> !devsel_o);
  p_no_type1_r2: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    (addr_strobe_i && ad_lo_i[1:0] != 2'b00 && !devsel_o) |=> !devsel_o);
endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile
  import cfg_pkg::*;
#(
  parameter logic [15:0] CMD_WMASK = 16'h0147
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 por_ni,
  input  logic                 wr_en_i,
  input  logic [IDX_W-1:0]     idx_i,
  input  logic [3:0]           be_i,
  input  logic [31:0]          wdata_i,
  output logic [15:0]          cmd_o,
  output logic [7:0]           lat_o,
  output logic [7:0]           int_line_o,
  output logic [31:BAR_LSB]    bar_o
);
  logic [3:0]  lane_we;
  logic [31:0] bar_full, bar_next;

  for (genvar k = 0; k < 4; k++) begin : g_lane
    assign lane_we[k] = wr_en_i & be_i[k];
    assign bar_next[8*k+7:8*k] = (lane_we[k] && idx_i == IDX_BAR) ?
                                 wdata_i[8*k+7:8*k] : bar_full[8*k+7:8*k];
  end
  assign bar_full = {bar_o, {BAR_LSB{1'b0}}};

  // Command word: the only field that the hard reset touches
  always_ff @(posedge clk_i or negedge rst_ni or negedge por_ni) begin
    if (!rst_ni || !por_ni) begin
      cmd_o <= '0;
    end else if (idx_i == IDX_CMD) begin
      if (lane_we[0]) cmd_o[7:0]  <= wdata_i[7:0]  & CMD_WMASK[7:0];
      if (lane_we[1]) cmd_o[15:8] <= wdata_i[15:8] & CMD_WMASK[15:8];
    end
  end

  always_ff @(posedge clk_i or negedge por_ni) begin
    if (!por_ni) begin
      lat_o      <= '0;
      int_line_o <= '0;
      bar_o      <= '0;
    end else begin
      if (idx_i == IDX_MISC && lane_we[1]) lat_o      <= wdata_i[15:8];
      if (idx_i == IDX_INT  && lane_we[0]) int_line_o <= wdata_i[7:0];
      bar_o <= bar_next[31:BAR_LSB];
    end
  end

  p_rsvd_wr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    (wr_en_i && idx_reserved(idx_i)) |=>
      ($stable(cmd_o) && $stable(lat_o) && $stable(int_line_o) && $stable(bar_o)));
  p_zero_be_r4: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    (wr_en_i && be_i == 4'b0000) |=>
      ($stable(cmd_o) && $stable(lat_o) && $stable(int_line_o) && $stable(bar_o)));
  p_idle_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    !wr_en_i |=> ($stable(lat_o) && $stable(int_line_o) && $stable(bar_o)));
endmodule

// File: rtl/cfg_read_mux.sv
module cfg_read_mux
  import cfg_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID  = 16'hABCD,
  parameter logic [15:0] DEVICE_ID  = 16'h5A17,
  parameter logic [15:0] STATUS_VAL = 16'h0280,
  parameter logic [23:0] CLASS_CODE = 24'h020000,
  parameter logic [7:0]  REVISION   = 8'h10,
  parameter logic [7:0]  INT_PIN    = 8'h01
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               por_ni,
  input  logic               rd_en_i,
  input  logic [IDX_W-1:0]   idx_i,
  input  logic [15:0]        cmd_i,
  input  logic [7:0]         lat_i,
  input  logic [7:0]         int_line_i,
  input  logic [31:BAR_LSB]  bar_i,
  output logic [31:0]        rdata_o,
  output logic               rvalid_o
);
  localparam logic [7:0] HDR_TYPE = 8'h00;  // bit 7 clear: single function
  logic [31:0] dword;

  always_comb begin
    unique case (idx_i)
      IDX_ID:    dword = {DEVICE_ID, VENDOR_ID};
      IDX_CMD:   dword = {STATUS_VAL, cmd_i};
      IDX_CLASS: dword = {CLASS_CODE, REVISION};
      IDX_MISC:  dword = {8'h00, HDR_TYPE, lat_i, 8'h00};
      IDX_BAR:   dword = {bar_i, {(BAR_LSB-1){1'b0}}, 1'b1};
      IDX_INT:   dword = {16'h0000, INT_PIN, int_line_i};
      default:   dword = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni or negedge por_ni) begin
    if (!rst_ni || !por_ni) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= rd_en_i;
      if (rd_en_i) rdata_o <= dword;
    end
  end

  p_rvalid_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    rvalid_o |=> !rvalid_o);
  p_rvalid_src_r4: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
    $rose(rvalid_o) |-> $past(rd_en_i));
endmodule

// File: rtl/cfg_target.sv
module cfg_target
  import cfg_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID  = 16'hABCD,
  parameter logic [15:0] DEVICE_ID  = 16'h5A17,
  parameter logic [15:0] STATUS_VAL = 16'h0280,
  parameter logic [15:0] CMD_WMASK  = 16'h0147,
  parameter logic [23:0] CLASS_CODE = 24'h020000,
  parameter logic [7:0]  REVISION   = 8'h10,
  parameter logic [7:0]  INT_PIN    = 8'h01
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        por_ni,
  input  logic        soft_rst_i,
  input  logic        sleep_i,
  input  logic        idsel_i,
  input  logic        addr_strobe_i,
  input  logic        data_strobe_i,
  input  logic        cfg_write_i,
  input  logic [31:0] ad_i,
  input  logic [3:0]  byte_en_i,
  output logic        devsel_o,
  output logic [31:0] rdata_o,
  output logic        rvalid_o
);
  logic [IDX_W-1:0]  idx;
  logic              wr_en, rd_en;
  logic [15:0]       cmd;
  logic [7:0]        lat, int_line;
  logic [31:BAR_LSB] bar;
  logic              unused_ign;

  // Soft reset and sleep deliberately leave configuration state alone
  assign unused_ign = soft_rst_i ^ sleep_i;

  cfg_addr_decode u_dec (
    .clk_i, .rst_ni, .por_ni, .idsel_i, .addr_strobe_i, .data_strobe_i,
    .cfg_write_i, .ad_lo_i(ad_i[7:0]), .devsel_o, .idx_o(idx),
    .wr_en_o(wr_en), .rd_en_o(rd_en)
  );

  cfg_regfile #(.CMD_WMASK(CMD_WMASK)) u_regs (
    .clk_i, .rst_ni, .por_ni, .wr_en_i(wr_en), .idx_i(idx), .be_i(byte_en_i),
    .wdata_i(ad_i), .cmd_o(cmd), .lat_o(lat), .int_line_o(int_line), .bar_o(bar)
  );

  cfg_read_mux #(
    .VENDOR_ID(VENDOR_ID), .DEVICE_ID(DEVICE_ID), .STATUS_VAL(STATUS_VAL),
    .CLASS_CODE(CLASS_CODE), .REVISION(REVISION), .INT_PIN(INT_PIN)
  ) u_rmux (
    .clk_i, .rst_ni, .por_ni, .rd_en_i(rd_en), .idx_i(idx), .cmd_i(cmd),
    .lat_i(lat), .int_line_i(int_line), .bar_i(bar), .rdata_o, .rvalid_o
  );

  p_hard_rst_cmd_r10: assert property (@(posedge clk_i) disable iff (!por_ni)
    !rst_ni |-> (cmd == 16'h0000));
endmodule

// File: tb/cfg_target_tb.sv
module cfg_target_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0, por_ni = 1'b0;
  logic        soft_rst_i = 1'b0, sleep_i = 1'b0;
  logic        idsel_i = 1'b0, addr_strobe_i = 1'b0, data_strobe_i = 1'b0;
  logic        cfg_write_i = 1'b0;
  logic [31:0] ad_i = '0;
  logic [3:0]  byte_en_i = '0;
  logic        devsel_o, rvalid_o;
  logic [31:0] rdata_o;

  int n_chk = 0, n_bad = 0, cycles = 0;

  always #2 clk = ~clk;  // 250 MHz

  cfg_target u_dut (
    .clk_i(clk), .rst_ni, .por_ni, .soft_rst_i, .sleep_i, .idsel_i,
    .addr_strobe_i, .data_strobe_i, .cfg_write_i, .ad_i, .byte_en_i,
    .devsel_o, .rdata_o, .rvalid_o
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  logic        last_claim, last_rv, last_drop;
  logic [31:0] last_rd;

  task automatic cyc(input logic [31:0] addr, input logic wr, input logic [3:0] be,
                     input logic [31:0] wd, input logic sel);
    @(negedge clk);
    idsel_i = sel; addr_strobe_i = 1'b1; cfg_write_i = wr; ad_i = addr;
    @(negedge clk);
    addr_strobe_i = 1'b0; idsel_i = 1'b0;
    last_claim = devsel_o;
    ad_i = wd; byte_en_i = be; data_strobe_i = 1'b1;
    @(negedge clk);
    data_strobe_i = 1'b0;
    last_rd = rdata_o; last_rv = rvalid_o; last_drop = ~devsel_o;
    @(negedge clk);
    if (rvalid_o) last_rv = 1'b0;  // pulse must not last two cycles
  endtask

  task automatic wr(input logic [31:0] a, input logic [3:0] be, input logic [31:0] d);
    cyc(a, 1'b1, be, d, 1'b1);
  endtask

  task automatic rd_chk(input string req, input logic [31:0] a, input logic [31:0] exp);
    cyc(a, 1'b0, 4'hF, 32'h0, 1'b1);
    check(req, {31'd0, last_rv}, 32'd1);
    check(req, last_rd, exp);
  endtask

  task automatic t_reset_state;
    rd_chk("R5 id", 32'h00, 32'h5A17ABCD);
    check("R1 claim", {31'd0, last_claim}, 32'd1);
    check("R1 drop", {31'd0, last_drop}, 32'd1);
    rd_chk("R7 cmd/status", 32'h04, 32'h02800000);
    rd_chk("R5 class", 32'h08, 32'h02000010);
    rd_chk("R5 hdr", 32'h0C, 32'h00000000);
    rd_chk("R8 bar", 32'h10, 32'h00000001);
    rd_chk("R5 intpin", 32'h3C, 32'h00000100);
  endtask

  task automatic t_claim;
    cyc(32'h00, 1'b0, 4'hF, 32'h0, 1'b0);
    check("R1 no idsel", {31'd0, last_claim}, 32'd0);
    check("R1 no idsel rv", {31'd0, last_rv}, 32'd0);
    cyc(32'h0D, 1'b1, 4'h2, 32'h0000FF00, 1'b1);
    check("R2 type1 claim", {31'd0, last_claim}, 32'd0);
    rd_chk("R2 type1 no write", 32'h0C, 32'h00000000);
  endtask

  task automatic t_bytes;
    wr(32'h0C, 4'b0010, 32'hAABBCCDD);
    rd_chk("R9 lat", 32'h0C, 32'h0000CC00);
    wr(32'h3C, 4'b0001, 32'h12345678);
    rd_chk("R9 intline", 32'h3C, 32'h00000178);
    wr(32'h10, 4'b1111, 32'hFFFFFFFF);
    rd_chk("R8 bar ones", 32'h10, 32'hFFFFFFE1);
    wr(32'h10, 4'b0100, 32'h00000000);
    rd_chk("R4 lane2", 32'h10, 32'hFF00FFE1);
    wr(32'h3C, 4'b0000, 32'h00000000);
    rd_chk("R4 zero be", 32'h3C, 32'h00000178);
    cyc(32'h08, 1'b0, 4'b0100, 32'h0, 1'b1);
    check("R4 subclass byte", {24'd0, last_rd[23:16]}, 32'h00);
    check("R4 full dword", last_rd, 32'h02000010);
  endtask

  task automatic t_fn_ignore;
    wr(32'hFFFFF73C, 4'b0001, 32'h00000055);
    rd_chk("R3 fn write", 32'h3C, 32'h00000155);
    rd_chk("R3 fn read", 32'h0000_0500, 32'h5A17ABCD);
  endtask

  task automatic t_readonly;
    wr(32'h00, 4'hF, 32'hFFFFFFFF);
    rd_chk("R5 id ro", 32'h00, 32'h5A17ABCD);
    wr(32'h08, 4'hF, 32'hFFFFFFFF);
    rd_chk("R5 class ro", 32'h08, 32'h02000010);
    wr(32'h0C, 4'hF, 32'hFFFFFFFF);
    rd_chk("R5 hdr bit7", 32'h0C, 32'h0000FF00);
    wr(32'h04, 4'hF, 32'hFFFFFFFF);
    rd_chk("R7 cmd mask", 32'h04, 32'h02800147);
  endtask

  task automatic t_reserved;
    wr(32'h14, 4'hF, 32'hFFFFFFFF);
    rd_chk("R6 dw5", 32'h14, 32'h0);
    wr(32'h50, 4'hF, 32'hFFFFFFFF);
    rd_chk("R6 dw20", 32'h50, 32'h0);
    rd_chk("R6 dw14", 32'h38, 32'h0);
    rd_chk("R6 others kept", 32'h3C, 32'h00000155);
  endtask

  task automatic t_resets;
    @(negedge clk); soft_rst_i = 1'b1; sleep_i = 1'b1;
    repeat (3) @(negedge clk);
    soft_rst_i = 1'b0; sleep_i = 1'b0;
    rd_chk("R11 cmd", 32'h04, 32'h02800147);
    rd_chk("R11 lat", 32'h0C, 32'h0000FF00);
    @(negedge clk); rst_ni = 1'b0;
    @(negedge clk); rst_ni = 1'b1;
    rd_chk("R10 cmd cleared", 32'h04, 32'h02800000);
    rd_chk("R10 lat kept", 32'h0C, 32'h0000FF00);
    rd_chk("R10 int kept", 32'h3C, 32'h00000155);
    rd_chk("R10 bar kept", 32'h10, 32'hFF00FFE1);
    @(negedge clk); por_ni = 1'b0;
    @(negedge clk); por_ni = 1'b1;
    // R12: read issued at the very next opportunity after power-on release
    idsel_i = 1'b1; addr_strobe_i = 1'b1; cfg_write_i = 1'b0; ad_i = 32'h10;
    @(negedge clk);
    addr_strobe_i = 1'b0; idsel_i = 1'b0;
    check("R12 claim", {31'd0, devsel_o}, 32'd1);
    data_strobe_i = 1'b1; byte_en_i = 4'hF;
    @(negedge clk);
    data_strobe_i = 1'b0;
    check("R12 data", rdata_o, 32'h00000001);
    rd_chk("R10 por lat", 32'h0C, 32'h0);
    rd_chk("R10 por int", 32'h3C, 32'h00000100);
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d expected <20000 cycles", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    por_ni = 1'b1; rst_ni = 1'b1;
    t_reset_state();
    t_claim();
    t_bytes();
    t_fn_ignore();
    t_readonly();
    t_reserved();
    t_resets();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule